// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the storage and sequencing element of a successive-approximation analog-to-digital converter. A synchronous, active-low start loads a trial word whose most significant bit is low and whose other bits are high. On every later clock that low trial bit steps one place toward the least significant end. The place it leaves takes the value on the serial data input, which is the comparator decision in a converter. After one clock per bit, the parallel word holds the full result and an active-low completion flag drops.

The same block can also work as a plain serial-to-parallel converter with the first bit received landing in the most significant place. Two further outputs are provided. One is a registered copy of the serial input, retimed to the clock. The other is the complement of the most significant bit. The comparator, the DAC and all analog parts lie outside this block. The register width is a parameter that defaults to 8.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block goes idle on that edge: `sar_q` is all ones, `done_n` is 1, `sdo` is 0 and `msb_n` is 0.
- R2: A rising edge with `rst` low and `start_n` low loads `sar_q` with the most significant bit 0 and all other bits 1, and sets `done_n` to 1.
- R3: On each later edge without start, the single low trial bit moves down by one place. After k data edges (k < WIDTH), bits WIDTH-1 down to WIDTH-k hold data, bit WIDTH-1-k is 0, and the lower bits are 1.
- R4: Data bits land in arrival order: the first bit after start goes to bit WIDTH-1, the second to bit WIDTH-2, and the WIDTH-th to bit 0.
- R5: `done_n` stays 1 from the start edge until the edge that stores the WIDTH-th data bit. It falls to 0 on that same edge.
- R6: Once `done_n` is 0, edges without start leave `sar_q` and `done_n` unchanged.
- R7: Start overrides shifting. Asserting it in the middle of a conversion reloads the trial word at once, and a complete new conversion follows.
- R8: `sdo` equals the value `din` had at the previous rising edge, on every edge with `rst` low.
- R9: `msb_n` always equals the complement of `sar_q[WIDTH-1]`.
- R10: After reset and before any start, edges leave `sar_q` all ones and `done_n` at 1, whatever `din` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Synchronous start, active low |
| din | input | 1 | Serial data / comparator decision |
| sar_q | output | WIDTH | Parallel register |
| msb_n | output | 1 | Complement of the most significant bit |
| sdo | output | 1 | Serial input delayed by one clock |
| done_n | output | 1 | Conversion complete, active low |

## Verification
The bench builds the block with the default WIDTH of 8. At that width, every one of the 256 possible data bytes can be fed through a full conversion in one short run. The walking trial bit is therefore seen next to every neighbouring data value, including all-zero and all-one words, where the low trial bit looks the same as a stored zero. A behavioural model based on a counter is compared with all outputs on every clock. This covers the idle, hold and mid-conversion restart phases as well as the conversions themselves.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_HOLD  = 2'd3
  } sar_op_e;
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_n,
  output sar_op_e        op,
  output logic [WIDTH:0] tok,
  output logic           done_n
);
  localparam logic [WIDTH:0] TOK_LOAD = {1'b1, {WIDTH{1'b0}}};

  // tok[i+1] marks the trial bit at position i; tok[0] is the guard stage below bit 0
  always_comb begin
    if (!start_n)          op = OP_LOAD;
    else if (|tok[WIDTH:1]) op = OP_SHIFT;
    else if (tok[0])        op = OP_HOLD;
    else                    op = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tok    <= '0;
      done_n <= 1'b1;
    end else begin
      unique case (op)
        OP_LOAD: begin
          tok    <= TOK_LOAD;
          done_n <= 1'b1;
        end
        OP_SHIFT: begin
          tok    <= tok >> 1;
          done_n <= ~tok[1];
        end
        default: begin
          tok    <= tok;
          done_n <= done_n;
        end
      endcase
    end
  end

  AST_TOK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tok)); // R3

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (start_n && tok[1]) |=> !done_n); // R5

  AST_DONE_HIGH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|tok[WIDTH:1]) |-> done_n); // R5
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell
  import sar_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  sar_op_e op,
  input  logic    mark_here,
  input  logic    mark_above,
  input  logic    din,
  output logic    q
);
  localparam logic LOAD_VAL = IS_MSB ? 1'b0 : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b1;
    end else begin
      unique case (op)
        OP_LOAD:  q <= LOAD_VAL;
        OP_SHIFT: begin
          if (mark_here)       q <= din;
          else if (mark_above) q <= 1'b0;
          else                 q <= q;
        end
        default:  q <= q;
      endcase
    end
  end

  AST_CELL_FILL: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT && mark_here) |=> (q == $past(din))); // R4
endmodule

// File: rtl/sar_sync_stage.sv
module sar_sync_stage #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             din,
  output logic [WIDTH-1:0] sar_q,
  output logic             msb_n,
  output logic             sdo,
  output logic             done_n
);
  localparam logic [WIDTH-1:0] LOAD_WORD = {1'b0, {(WIDTH-1){1'b1}}};

  sar_op_e          op;
  logic [WIDTH:0]   tok;
  logic [WIDTH+1:0] tok_ext;

  sar_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .op      (op),
    .tok     (tok),
    .done_n  (done_n)
  );

  assign tok_ext = {1'b0, tok};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    sar_bit_cell #(.IS_MSB(i == WIDTH-1)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .op         (op),
      .mark_here  (tok_ext[i+1]),
      .mark_above (tok_ext[i+2]),
      .din        (din),
      .q          (sar_q[i])
    );
  end

  // complement of the MSB, kept in its own flop so the output is registered
  always_ff @(posedge clk) begin
    if (rst) begin
      msb_n <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD:  msb_n <= 1'b1;
        OP_SHIFT: msb_n <= tok[WIDTH] ? ~din : msb_n;
        default:  msb_n <= msb_n;
      endcase
    end
  end

  sar_sync_stage #(.STAGES(1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (sdo)
  );

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (rst)
    (!start_n) |=> (sar_q == LOAD_WORD && done_n)); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!done_n && start_n) |=> (!done_n && $stable(sar_q))); // R6

  AST_SYNC_DATA: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sdo == $past(din))); // R8

  AST_MSB_COMP: assert property (@(posedge clk) disable iff (rst)
    msb_n == ~sar_q[WIDTH-1]); // R9
endmodule

// File: tb/test_sar_ctrl.sv
module test_sar_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_n = 1'b1;
  logic         din = 1'b0;
  logic [W-1:0] sar_q;
  logic         msb_n, sdo, done_n;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [W-1:0] m_q = '1;
  logic         m_done_n = 1'b1;
  logic         m_sdo = 1'b0;
  int           m_cnt = -1;

  always #10 clk = ~clk;

  sar_ctrl #(.WIDTH(W)) i_sar_ctrl (
    .clk(clk), .rst(rst), .start_n(start_n), .din(din),
    .sar_q(sar_q), .msb_n(msb_n), .sdo(sdo), .done_n(done_n)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic d, input string tag);
    @(negedge clk);
    rst = r; start_n = s; din = d;
    @(posedge clk);
    if (r) begin
      m_q = '1; m_done_n = 1'b1; m_sdo = 1'b0; m_cnt = -1;
    end else begin
      m_sdo = d;
      if (!s) begin
        m_q = {1'b0, {(W-1){1'b1}}}; m_done_n = 1'b1; m_cnt = 0;
      end else if (m_cnt >= 0 && m_cnt < W) begin
        m_q[W-1-m_cnt] = d;
        if (m_cnt + 1 < W) m_q[W-2-m_cnt] = 1'b0;
        m_cnt++;
        if (m_cnt == W) m_done_n = 1'b0;
      end
    end
    #5;
    chk(sar_q === m_q, tag, "sar_q", sar_q, m_q);
    chk(done_n === m_done_n, r ? "R1" : "R5", "done_n", W'(done_n), W'(m_done_n));
    chk(sdo === m_sdo, r ? "R1" : "R8", "sdo", W'(sdo), W'(m_sdo));
    chk(msb_n === ~m_q[W-1], r ? "R1" : "R9", "msb_n", W'(msb_n), W'(~m_q[W-1]));
  endtask

  initial begin
    step(1'b1, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b1, "R1");
    // idle: no start yet, din toggling (R10)
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, k[0], "R10");
    // every byte pattern through a full conversion
    for (int v = 0; v < 256; v++) begin
      step(1'b0, 1'b0, v[0], "R2");
      for (int j = 0; j < W; j++)
        step(1'b0, 1'b1, v[W-1-j], (j < W-1) ? "R3" : "R4");
      if (v % 16 == 0)
        for (int h = 0; h < 3; h++) step(1'b0, 1'b1, h[0] ^ v[1], "R6");
    end
    // restart in the middle of a conversion (R7)
    step(1'b0, 1'b0, 1'b1, "R2");
    for (int j = 0; j < 3; j++) step(1'b0, 1'b1, 1'b1, "R3");
    step(1'b0, 1'b0, 1'b0, "R7");
    for (int j = 0; j < W; j++) step(1'b0, 1'b1, j[0], "R7");
    step(1'b0, 1'b1, 1'b1, "R6");
    // reset during a conversion returns to idle
    step(1'b0, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b0, "R1");
    for (int k = 0; k < 2; k++) step(1'b0, 1'b1, 1'b0, "R10");
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule